// File: doc/BRIEF.md
# Register Rename Table with Free Pool

This block gives every destination register of an incoming instruction a new physical register. It does this to remove the false write-after-read and write-after-write conflicts that come from reusing architectural register numbers. A mapping table holds the current physical name of each architectural register. Each request reads the physical names of its two sources from this table. The same request takes the lowest-numbered free physical register for its destination and writes that register into the table entry of the destination.

Every physical register carries a reference count of in-flight readers. A renamed source raises the count by one. A reader-done notification lowers it by one. A physical register that has lost its table entry is marked superseded. It goes back to the free pool once its count reaches zero. When the pool is empty, the block raises a stall output and ignores requests until a register comes back.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers NARCH to NPHYS-1 are free, stall is 0 and rsp_valid is 0.
- R2: A request with req_valid=1 while stall=0 is accepted, and rsp_valid is 1 for exactly the following cycle.
- R3: In that response, rsp_psrc0 and rsp_psrc1 are the physical registers mapped to req_src0 and req_src1 before the request. This holds even when a source equals req_dst.
- R4: rsp_pdst is the lowest-numbered free physical register. It never equals either source's physical register.
- R5: After an accepted request, later requests that read req_dst receive the new rsp_pdst. A later write to the same architectural register receives a different physical register.
- R6: A superseded physical register with a reference count of zero can be allocated to a request accepted two or more clock edges after the edge that superseded it.
- R7: Each source occurrence adds one reference, and each done notification (done_valid=1, register done_preg) removes one. A superseded register with references left is not allocated until the count reaches zero, and then follows R6.
- R8: stall is 1 exactly when no physical register is free. A request made while stall=1 produces no response and leaves the mapping unchanged.
- R9: Once a register is reclaimed, stall returns to 0 on the next edge and that register can be allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_src0 | input | $clog2(NARCH) | First source architectural register |
| req_src1 | input | $clog2(NARCH) | Second source architectural register |
| req_dst | input | $clog2(NARCH) | Destination architectural register |
| stall | output | 1 | Free pool empty; requests are not accepted |
| rsp_valid | output | 1 | Response for the request accepted on the previous edge |
| rsp_psrc0 | output | $clog2(NPHYS) | Physical name of first source |
| rsp_psrc1 | output | $clog2(NPHYS) | Physical name of second source |
| rsp_pdst | output | $clog2(NPHYS) | Newly allocated physical destination |
| done_valid | input | 1 | A reader has finished with a physical register |
| done_preg | input | $clog2(NPHYS) | Physical register whose reader finished |

## Verification
The checks assume three things about the inputs. A done notification only names a physical register that still has at least one outstanding reference. At most one notification arrives per cycle. No count is raised beyond what its width can hold. The stimulus meets all three: it sends a done only for registers it has read as sources, one per call, and it keeps a register's reader count to a few. Under those conditions, the checks confirm the following. A response always follows an accepted request. A stalled request gets no response. A free register never carries references. An allocated destination never repeats its sources or the destination given on the cycle before.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NARCH = 8,
  parameter int NPHYS = 16,
  parameter int CNTW  = 4,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_src0,
  input  logic [AW-1:0] req_src1,
  input  logic [AW-1:0] req_dst,
  output logic          stall,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_psrc0,
  output logic [PW-1:0] rsp_psrc1,
  output logic [PW-1:0] rsp_pdst,
  input  logic          done_valid,
  input  logic [PW-1:0] done_preg
);

  logic [PW-1:0]   map_q [NARCH];
  logic [CNTW-1:0] cnt_q [NPHYS];
  logic [CNTW-1:0] cnt_d [NPHYS];
  logic [NPHYS-1:0] free_q, sup_q, live, reclaim, alloc_oh, old_oh;
  logic [PW-1:0] alloc, ps0, ps1, pold;
  logic fire;

  assign stall = ~|free_q;
  assign fire  = req_valid & ~stall;
  assign ps0   = map_q[req_src0];
  assign ps1   = map_q[req_src1];
  assign pold  = map_q[req_dst];

  always_comb begin
    alloc = '0;
    for (int p = NPHYS - 1; p >= 0; p--)
      if (free_q[p]) alloc = PW'(p);
  end

  always_comb begin
    for (int p = 0; p < NPHYS; p++) begin
      logic [1:0] inc;
      logic       dec;
      inc = 2'(fire && ps0 == PW'(p)) + 2'(fire && ps1 == PW'(p));
      dec = done_valid && done_preg == PW'(p);
      cnt_d[p]    = cnt_q[p] + CNTW'(inc) - CNTW'(dec);
      live[p]     = cnt_q[p] != '0;
      alloc_oh[p] = fire && alloc == PW'(p);
      old_oh[p]   = fire && pold == PW'(p);
    end
  end

  assign reclaim = sup_q & ~live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= PW'(i);
      for (int p = 0; p < NPHYS; p++) begin
        cnt_q[p]  <= '0;
        free_q[p] <= p >= NARCH;
      end
      sup_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_psrc0 <= '0;
      rsp_psrc1 <= '0;
      rsp_pdst  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_psrc0      <= ps0;
        rsp_psrc1      <= ps1;
        rsp_pdst       <= alloc;
        map_q[req_dst] <= alloc;
      end
      for (int p = 0; p < NPHYS; p++) cnt_q[p] <= cnt_d[p];
      free_q <= (free_q | reclaim) & ~alloc_oh;
      sup_q  <= (sup_q & ~reclaim) | old_oh;
    end
  end

endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NPHYS = 16,
  parameter int PW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             stall,
  input logic             rsp_valid,
  input logic [PW-1:0]    rsp_psrc0,
  input logic [PW-1:0]    rsp_psrc1,
  input logic [PW-1:0]    rsp_pdst,
  input logic             done_valid,
  input logic [PW-1:0]    done_preg,
  input logic [NPHYS-1:0] free_q,
  input logic [NPHYS-1:0] live
);

  // R2
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !stall));

  // R8
  stalled_req_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stall) |=> !rsp_valid);

  // R4
  fresh_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_pdst != rsp_psrc0 && rsp_pdst != rsp_psrc1));

  // R4
  distinct_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rsp_valid)) |-> rsp_pdst != $past(rsp_pdst));

  // R7
  free_unreferenced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q & live) == '0);

  // R7
  done_has_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> live[done_preg]);

endmodule

bind rename_map rename_map_chk #(.NPHYS(NPHYS), .PW(PW)) u_chk (.*);

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, done_valid = 1'b0;
  logic [AW-1:0] req_src0 = '0, req_src1 = '0, req_dst = '0;
  logic [PW-1:0] done_preg = '0;
  logic stall, rsp_valid;
  logic [PW-1:0] rsp_psrc0, rsp_psrc1, rsp_pdst;
  int n_chk = 0, n_fail = 0;

  rename_map #(.NARCH(NA), .NPHYS(NP), .CNTW(4)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src0(req_src0),
    .req_src1(req_src1), .req_dst(req_dst), .stall(stall), .rsp_valid(rsp_valid),
    .rsp_psrc0(rsp_psrc0), .rsp_psrc1(rsp_psrc1), .rsp_pdst(rsp_pdst),
    .done_valid(done_valid), .done_preg(done_preg));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rename(input int s0, input int s1, input int d,
                        output int p0, output int p1, output int pd, output bit v);
    req_valid = 1'b1; req_src0 = AW'(s0); req_src1 = AW'(s1); req_dst = AW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; p0 = int'(rsp_psrc0); p1 = int'(rsp_psrc1); pd = int'(rsp_pdst);
  endtask

  task automatic done(input int p);
    done_valid = 1'b1; done_preg = PW'(p);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    int p0, p1, pd; bit v;
    do_reset();
    chk(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    rename(2, 7, 0, p0, p1, pd, v);
    chk(v, "R2 response valid", int'(v), 1);
    chk(p0 == 2, "R1 identity map src0", p0, 2);
    chk(p1 == 7, "R1 identity map src1", p1, 7);
    chk(pd == NA, "R1 first free register", pd, NA);
  endtask

  task automatic t_sequence();
    int p0, p1, pd, pd1; bit v;
    do_reset();
    rename(3, 5, 3, p0, p1, pd, v);
    chk(p0 == 3, "R3 read old mapping of own dest", p0, 3);
    chk(p1 == 5, "R3 src1 mapping", p1, 5);
    chk(pd == 8, "R4 lowest free", pd, 8);
    pd1 = pd;
    rename(3, 0, 4, p0, p1, pd, v);
    chk(p0 == pd1, "R5 reader sees new name", p0, pd1);
    chk(pd == 9, "R4 next free", pd, 9);
    rename(5, 0, 3, p0, p1, pd, v);
    chk(pd == 10, "R6 reclaim not before second edge", pd, 10);
    chk(pd != pd1, "R5 rewrite gets new register", pd, pd1 + 1);
    repeat (2) @(negedge clk);
    rename(1, 2, 6, p0, p1, pd, v);
    chk(pd == 4, "R6 zero-ref superseded reused", pd, 4);
    repeat (2) @(negedge clk);
    rename(1, 1, 7, p0, p1, pd, v);
    chk(pd == 6, "R7 referenced register held back", pd, 6);
    done(3);
    repeat (2) @(negedge clk);
    rename(3, 4, 0, p0, p1, pd, v);
    chk(p0 == 10 && p1 == 9, "R5 current mappings", p0 * 100 + p1, 1009);
    chk(pd == 3, "R7 reused after reader drained", pd, 3);
  endtask

  task automatic t_stall();
    int p0, p1, pd; bit v;
    do_reset();
    for (int i = 0; i < NP - NA; i++) begin
      rename(1, 1, 1, p0, p1, pd, v);
      chk(pd == NA + i, "R4 fill pool in order", pd, NA + i);
    end
    chk(stall == 1'b1, "R8 stall on empty pool", int'(stall), 1);
    rename(0, 0, 2, p0, p1, pd, v);
    chk(v == 1'b0, "R8 stalled request ignored", int'(v), 0);
    done(14);
    chk(stall == 1'b1, "R7 count not yet zero", int'(stall), 1);
    done(14);
    chk(stall == 1'b1, "R9 reclaim one edge later", int'(stall), 1);
    @(negedge clk);
    chk(stall == 1'b0, "R9 stall clears", int'(stall), 0);
    rename(2, 2, 5, p0, p1, pd, v);
    chk(v && p0 == 2, "R8 mapping untouched by stalled request", p0, 2);
    chk(pd == 14, "R9 reclaimed register allocated", pd, 14);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule